// File: doc/BRIEF.md
# Fetch and Memory Access Sequencer

This block is the control state machine of a non-pipelined core. For each instruction it sends one fetch on an instruction port. If the fetched instruction references memory, it then sends exactly one access on a separate data port. Both ports use a request/response protocol:

- A request is a one-cycle pulse that the memory accepts or refuses in the same cycle.
- A refused request waits for a retry strobe.
- A response may arrive later, or may come back negatively acknowledged, in which case it must be resent.

Decode, execution and translation sit outside the block. They appear only as handshakes: an instruction-valid pulse, the is-memory and is-prefetch qualifiers, and fault inputs.

The sequencer also takes control commands. Activate starts fetching after a delay. Suspend returns the core to idle. Switch-out parks the core. Drain asks the core to quiesce, and resume ends a drain. Drain is acknowledged once nothing is in flight. A command given in the wrong state sets a sticky error flag. Every output comes from a register.

Top module: `fetch_mem_seq`

## Requirements
- R1: After reset the state is idle, all request, valid, acknowledge and error outputs are low, and the retired count is zero.
- R2: Activate is taken from idle and enters running with the given delay D. The first fetch request appears in the cycle after the (D+1)-th clock edge following the edge that samples activate.
- R3: A fetch request refused in its cycle moves the state to instruction-retry. A retry strobe there resends the request in the next cycle, and the state becomes instruction-wait.
- R4: A response is registered at the edge that samples it. The matching valid pulse (inst_valid_o or acc_done_o) is high in the following cycle, and the block acts on it at the next edge.
- R5: A memory instruction that is not a prefetch starts a data request in the cycle after the valid pulse. Any other instruction completes at that edge, and the next fetch request follows at once. Request and valid outputs are never high together.
- R6: A fetch fault at an issue edge sends no request and keeps the state running without retiring. Fetch is tried again at the next edge.
- R7: A negatively acknowledged response on either port is resent in the next cycle. A refused data request, or a refused resend, moves to the retry state of that port.
- R8: The retired count rises by one only when an instruction completes without a fault. The fault is exec_fault_i for non-memory instructions and acc_fault_i for data accesses.
- R9: Drain is acknowledged one cycle after the request when the state is idle, running or switched-out. Otherwise it is held pending and acknowledged when the current instruction completes. After an acknowledge in running, no fetch is issued until resume; after resume, the fetch comes at the second edge.
- R10: Suspend is legal only in running and moves to idle. Activate is legal only in idle. Switch-out is legal in idle or running and moves to switched-out. Resume is legal only while drained. Any illegal command sets err_o, which stays set until reset.
- R11: The state_o encoding is idle 0, running 1, instruction-retry 2, instruction-wait 3, data-retry 4, data-wait 5, switched-out 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activate_i | input | 1 | Start fetching from idle |
| act_delay_i | input | DLY_W | Cycles to wait before the first fetch |
| suspend_i | input | 1 | Return from running to idle |
| switch_out_i | input | 1 | Park the core |
| drain_req_i | input | 1 | Request quiescence |
| resume_i | input | 1 | Leave the drained condition |
| drain_ack_o | output | 1 | One-cycle drain acknowledge |
| err_o | output | 1 | Sticky illegal-command flag |
| state_o | output | 3 | Current state (R11) |
| retired_o | output | CNT_W | Fault-free retired instructions |
| fetch_fault_i | input | 1 | Fetch of the next instruction faults |
| if_req_o | output | 1 | Instruction request pulse |
| if_ready_i | input | 1 | Instruction request accepted this cycle |
| if_retry_i | input | 1 | Instruction port may be retried |
| if_rsp_i | input | 1 | Instruction response |
| if_nack_i | input | 1 | Instruction response negatively acknowledged |
| inst_valid_o | output | 1 | Fetched instruction ready for execution |
| is_mem_i | input | 1 | Instruction references memory |
| is_pref_i | input | 1 | Instruction is a prefetch |
| exec_fault_i | input | 1 | Non-memory instruction faulted |
| dm_req_o | output | 1 | Data request pulse |
| dm_ready_i | input | 1 | Data request accepted this cycle |
| dm_retry_i | input | 1 | Data port may be retried |
| dm_rsp_i | input | 1 | Data response |
| dm_nack_i | input | 1 | Data response negatively acknowledged |
| acc_done_o | output | 1 | Data access response ready for completion |
| acc_fault_i | input | 1 | Data access completed with a fault |

## Verification
Randomly drawn instructions mix several behaviours: refusals, negative acknowledges with accepted or refused resends, response latencies, memory, prefetch and plain instructions, and fetch, execute and access faults. Each pattern isolates a different state transition or a different retire decision. Directed sequences handle the cases that random traffic does not reach on its own:
- the activate delay count;
- drain while an access is in flight, against drain while running or idle;
- the hold until resume;
- the legal and illegal uses of suspend, switch-out and activate.

// File: rtl/fetch_mem_seq.sv
module fetch_mem_seq #(
  parameter int DLY_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activate_i,
  input  logic [DLY_W-1:0] act_delay_i,
  input  logic             suspend_i,
  input  logic             switch_out_i,
  input  logic             drain_req_i,
  input  logic             resume_i,
  output logic             drain_ack_o,
  output logic             err_o,
  output logic [2:0]       state_o,
  output logic [CNT_W-1:0] retired_o,
  input  logic             fetch_fault_i,
  output logic             if_req_o,
  input  logic             if_ready_i,
  input  logic             if_retry_i,
  input  logic             if_rsp_i,
  input  logic             if_nack_i,
  output logic             inst_valid_o,
  input  logic             is_mem_i,
  input  logic             is_pref_i,
  input  logic             exec_fault_i,
  output logic             dm_req_o,
  input  logic             dm_ready_i,
  input  logic             dm_retry_i,
  input  logic             dm_rsp_i,
  input  logic             dm_nack_i,
  output logic             acc_done_o,
  input  logic             acc_fault_i
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_RUN = 3'd1, S_IRETRY = 3'd2, S_IWAIT = 3'd3,
    S_DRETRY = 3'd4, S_DWAIT = 3'd5, S_SWOUT = 3'd6
  } st_e;

  st_e              st, st_n;
  logic [DLY_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] ret, ret_n;
  logic ireq, ireq_n, dreq, dreq_n, idone, idone_n, ddone, ddone_n;
  logic ack, ack_n, err, err_n, pend, pend_n, drained, drained_n;
  logic issue, finish, bad;

  assign state_o      = st;
  assign retired_o    = ret;
  assign if_req_o     = ireq;
  assign dm_req_o     = dreq;
  assign inst_valid_o = idone;
  assign acc_done_o   = ddone;
  assign drain_ack_o  = ack;
  assign err_o        = err;

  assign bad = (suspend_i && st != S_RUN)
             || (activate_i && st != S_IDLE)
             || (switch_out_i && st != S_IDLE && st != S_RUN)
             || (resume_i && !(st == S_RUN && drained));

  always_comb begin
    st_n = st; cnt_n = cnt; ret_n = ret;
    ireq_n = 1'b0; dreq_n = 1'b0; idone_n = 1'b0; ddone_n = 1'b0;
    ack_n = 1'b0; err_n = err | bad; pend_n = pend; drained_n = drained;
    issue = 1'b0; finish = 1'b0;

    if (drain_req_i) begin
      if (st == S_IDLE || st == S_RUN || st == S_SWOUT) ack_n = 1'b1;
      else pend_n = 1'b1;
      if (st == S_RUN) drained_n = 1'b1;
    end

    case (st)
      S_IDLE: begin
        if (activate_i) begin
          st_n = S_RUN; cnt_n = act_delay_i; drained_n = 1'b0;
        end else if (switch_out_i) st_n = S_SWOUT;
      end
      S_RUN: begin
        if (suspend_i) st_n = S_IDLE;
        else if (switch_out_i) st_n = S_SWOUT;
        else if (resume_i && drained) drained_n = 1'b0;
        else if (!drained && !drain_req_i) begin
          if (cnt != '0) cnt_n = cnt - 1'b1;
          else issue = 1'b1;
        end
      end
      S_IRETRY: if (if_retry_i) begin ireq_n = 1'b1; st_n = S_IWAIT; end
      S_IWAIT: begin
        if (ireq) begin
          if (!if_ready_i) st_n = S_IRETRY;
        end else if (idone) begin
          if (is_mem_i && !is_pref_i) begin
            dreq_n = 1'b1; st_n = S_DWAIT;
          end else begin
            if (!exec_fault_i) ret_n = ret + CNT_W'(1);
            finish = 1'b1;
          end
        end else if (if_rsp_i) idone_n = 1'b1;
        else if (if_nack_i) ireq_n = 1'b1;
      end
      S_DRETRY: if (dm_retry_i) begin dreq_n = 1'b1; st_n = S_DWAIT; end
      S_DWAIT: begin
        if (dreq) begin
          if (!dm_ready_i) st_n = S_DRETRY;
        end else if (ddone) begin
          if (!acc_fault_i) ret_n = ret + CNT_W'(1);
          finish = 1'b1;
        end else if (dm_rsp_i) ddone_n = 1'b1;
        else if (dm_nack_i) dreq_n = 1'b1;
      end
      default: ;
    endcase

    if (finish) begin
      if (pend || drain_req_i) begin
        ack_n = 1'b1; pend_n = 1'b0; drained_n = 1'b1; st_n = S_RUN;
      end else issue = 1'b1;
    end

    if (issue) begin
      if (fetch_fault_i) st_n = S_RUN;
      else begin ireq_n = 1'b1; st_n = S_IWAIT; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ret <= '0;
      ireq <= 1'b0; dreq <= 1'b0; idone <= 1'b0; ddone <= 1'b0;
      ack <= 1'b0; err <= 1'b0; pend <= 1'b0; drained <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; ret <= ret_n;
      ireq <= ireq_n; dreq <= dreq_n; idone <= idone_n; ddone <= ddone_n;
      ack <= ack_n; err <= err_n; pend <= pend_n; drained <= drained_n;
    end
  end

  a_r3_refused_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    if_req_o && !if_ready_i |=> state_o == S_IRETRY);
  a_r3_retry_resend: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == S_IRETRY && if_retry_i |=> if_req_o);
  a_r4_rsp_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == S_IWAIT && !if_req_o && !inst_valid_o && if_rsp_i |=> inst_valid_o);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({if_req_o, dm_req_o, inst_valid_o, acc_done_o}));
  a_r7_data_nack: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == S_DWAIT && !dm_req_o && !acc_done_o && !dm_rsp_i && dm_nack_i |=> dm_req_o);
  a_r8_retire_only_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(inst_valid_o || acc_done_o) |=> $stable(retired_o));
  a_r9_drain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req_i && (state_o == S_IDLE || state_o == S_SWOUT) |=> drain_ack_o);
  a_r10_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == S_RUN && suspend_i |=> state_o == S_IDLE);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

// File: tb/fetch_mem_seq_bench.sv
module fetch_mem_seq_bench;
  localparam int DLY_W = 8;
  localparam int CNT_W = 32;
  localparam logic [2:0] ST_IDLE = 3'd0, ST_RUN = 3'd1, ST_IRETRY = 3'd2,
    ST_IWAIT = 3'd3, ST_DRETRY = 3'd4, ST_DWAIT = 3'd5, ST_SWOUT = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic activate_i = 0, suspend_i = 0, switch_out_i = 0, drain_req_i = 0, resume_i = 0;
  logic [DLY_W-1:0] act_delay_i = '0;
  logic drain_ack_o, err_o, if_req_o, inst_valid_o, dm_req_o, acc_done_o;
  logic [2:0] state_o;
  logic [CNT_W-1:0] retired_o;
  logic fetch_fault_i = 0, if_ready_i = 1, if_retry_i = 0, if_rsp_i = 0, if_nack_i = 0;
  logic is_mem_i = 0, is_pref_i = 0, exec_fault_i = 0;
  logic dm_ready_i = 1, dm_retry_i = 0, dm_rsp_i = 0, dm_nack_i = 0, acc_fault_i = 0;

  int checks = 0, errors = 0, cyc = 0;
  int exp_ret = 0;

  fetch_mem_seq #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_fetch_mem_seq (
    .clk(clk), .rst_n(rst_n), .activate_i(activate_i), .act_delay_i(act_delay_i),
    .suspend_i(suspend_i), .switch_out_i(switch_out_i), .drain_req_i(drain_req_i),
    .resume_i(resume_i), .drain_ack_o(drain_ack_o), .err_o(err_o), .state_o(state_o),
    .retired_o(retired_o), .fetch_fault_i(fetch_fault_i), .if_req_o(if_req_o),
    .if_ready_i(if_ready_i), .if_retry_i(if_retry_i), .if_rsp_i(if_rsp_i),
    .if_nack_i(if_nack_i), .inst_valid_o(inst_valid_o), .is_mem_i(is_mem_i),
    .is_pref_i(is_pref_i), .exec_fault_i(exec_fault_i), .dm_req_o(dm_req_o),
    .dm_ready_i(dm_ready_i), .dm_retry_i(dm_retry_i), .dm_rsp_i(dm_rsp_i),
    .dm_nack_i(dm_nack_i), .acc_done_o(acc_done_o), .acc_fault_i(acc_fault_i));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int retire_inc(bit mem, bit ef, bit af);
    return mem ? (af ? 0 : 1) : (ef ? 0 : 1);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wait_req_i();
    for (int k = 0; k < 20 && !if_req_o; k++) step();
    chk(if_req_o == 1'b1, "R5 fetch request", int'(if_req_o), 1);
  endtask

  task automatic accept_i(bit refuse);
    if (refuse) begin
      if_ready_i = 0; step(); if_ready_i = 1;
      chk(state_o == ST_IRETRY, "R3 retry state", state_o, ST_IRETRY);
      if_retry_i = 1; step(); if_retry_i = 0;
      chk(if_req_o == 1'b1, "R3 resend", if_req_o, 1);
    end
    step();
    chk(state_o == ST_IWAIT, "R3 wait state", state_o, ST_IWAIT);
  endtask

  task automatic accept_d(bit refuse);
    if (refuse) begin
      dm_ready_i = 0; step(); dm_ready_i = 1;
      chk(state_o == ST_DRETRY, "R7 data retry state", state_o, ST_DRETRY);
      dm_retry_i = 1; step(); dm_retry_i = 0;
      chk(dm_req_o == 1'b1, "R7 data resend", dm_req_o, 1);
    end
    step();
    chk(state_o == ST_DWAIT, "R7 data wait state", state_o, ST_DWAIT);
  endtask

  task automatic run_inst(bit refuse, bit nack, int lat, bit mem, bit pf, bit ef, bit ff,
                          bit dref, bit dnack, bit dnref, int dlat, bit af);
    bit eff_mem;
    eff_mem = mem && !pf;
    wait_req_i();
    accept_i(refuse);
    repeat (lat) step();
    if (nack) begin
      if_nack_i = 1; step(); if_nack_i = 0;
      chk(if_req_o == 1'b1, "R7 fetch nack resend", if_req_o, 1);
      accept_i(0);
    end
    if_rsp_i = 1; step(); if_rsp_i = 0;
    chk(inst_valid_o == 1'b1, "R4 inst valid after response", inst_valid_o, 1);
    is_mem_i = mem; is_pref_i = pf; exec_fault_i = ef;
    if (!eff_mem) fetch_fault_i = ff;
    step();
    is_mem_i = 0; is_pref_i = 0; exec_fault_i = 0;
    if (eff_mem) begin
      chk(dm_req_o == 1'b1 && if_req_o == 1'b0, "R5 data request", dm_req_o, 1);
      accept_d(dref);
      repeat (dlat) step();
      if (dnack) begin
        dm_nack_i = 1; step(); dm_nack_i = 0;
        chk(dm_req_o == 1'b1, "R7 data nack resend", dm_req_o, 1);
        accept_d(dnref);
      end
      dm_rsp_i = 1; step(); dm_rsp_i = 0;
      chk(acc_done_o == 1'b1, "R4 access done after response", acc_done_o, 1);
      acc_fault_i = af; fetch_fault_i = ff;
      step();
      acc_fault_i = 0;
    end
    exp_ret += retire_inc(eff_mem, ef, af);
    chk(retired_o == CNT_W'(exp_ret), "R8 retired count", int'(retired_o), exp_ret);
    if (ff) begin
      chk(if_req_o == 1'b0 && state_o == ST_RUN, "R6 fetch fault no request", state_o, ST_RUN);
      fetch_fault_i = 0; step();
      chk(if_req_o == 1'b1, "R6 fetch after fault", if_req_o, 1);
    end else begin
      chk(if_req_o == 1'b1 && state_o == ST_IWAIT, "R5 next fetch at once", if_req_o, 1);
    end
  endtask

  task automatic drain_inst();
    wait_req_i();
    accept_i(0);
    drain_req_i = 1; step(); drain_req_i = 0;
    chk(drain_ack_o == 1'b0, "R9 drain pending", drain_ack_o, 0);
    if_rsp_i = 1; step(); if_rsp_i = 0;
    is_mem_i = 0; exec_fault_i = 0; step();
    exp_ret++;
    chk(drain_ack_o == 1'b1 && state_o == ST_RUN && if_req_o == 1'b0,
        "R9 drain ack on completion", drain_ack_o, 1);
    repeat (3) step();
    chk(if_req_o == 1'b0 && state_o == ST_RUN, "R9 hold while drained", if_req_o, 0);
  endtask

  initial begin
    int k;
    void'($urandom(32'd1234));
    repeat (3) step();
    rst_n = 1; step();
    chk(state_o == ST_IDLE, "R1 R11 reset state idle", state_o, ST_IDLE);
    chk({if_req_o, dm_req_o, inst_valid_o, acc_done_o, drain_ack_o, err_o} == 6'b0,
        "R1 outputs low", 0, 0);
    chk(retired_o == '0, "R1 retired zero", int'(retired_o), 0);

    activate_i = 1; act_delay_i = 8'd3; step(); activate_i = 0;
    chk(state_o == ST_RUN, "R2 running", state_o, ST_RUN);
    k = 1;
    while (!if_req_o && k < 20) begin step(); k++; end
    chk(k == 5, "R2 activate delay", k, 5);

    for (int i = 0; i < 40; i++) begin
      run_inst(($urandom % 4) == 0, ($urandom % 4) == 0, int'($urandom % 4),
               ($urandom % 2) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
               ($urandom % 6) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
               ($urandom % 2) == 0, int'($urandom % 4), ($urandom % 4) == 0);
    end
    run_inst(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    run_inst(0, 0, 1, 1, 0, 0, 1, 0, 1, 1, 2, 1);

    drain_inst();
    drain_req_i = 1; step(); drain_req_i = 0;
    chk(drain_ack_o == 1'b1, "R9 immediate ack running", drain_ack_o, 1);
    resume_i = 1; step(); resume_i = 0; step();
    chk(if_req_o == 1'b1 && err_o == 1'b0, "R9 fetch after resume", if_req_o, 1);

    drain_inst();
    suspend_i = 1; step(); suspend_i = 0;
    chk(state_o == ST_IDLE && err_o == 1'b0, "R10 suspend to idle", state_o, ST_IDLE);
    drain_req_i = 1; step(); drain_req_i = 0;
    chk(drain_ack_o == 1'b1, "R9 immediate ack idle", drain_ack_o, 1);
    activate_i = 1; act_delay_i = 8'd0; step(); activate_i = 0;
    k = 1;
    while (!if_req_o && k < 20) begin step(); k++; end
    chk(k == 2, "R2 zero delay", k, 2);
    accept_i(0);
    suspend_i = 1; step(); suspend_i = 0;
    chk(err_o == 1'b1 && state_o == ST_IWAIT, "R10 illegal suspend", err_o, 1);
    repeat (2) step();
    chk(err_o == 1'b1, "R10 error sticky", err_o, 1);

    rst_n = 0; step(); rst_n = 1; step();
    chk(err_o == 1'b0 && state_o == ST_IDLE, "R1 reset clears", state_o, ST_IDLE);
    switch_out_i = 1; step(); switch_out_i = 0;
    chk(state_o == ST_SWOUT && err_o == 1'b0, "R10 R11 switch out", state_o, ST_SWOUT);
    drain_req_i = 1; step(); drain_req_i = 0;
    chk(drain_ack_o == 1'b1, "R9 immediate ack switched out", drain_ack_o, 1);
    activate_i = 1; step(); activate_i = 0;
    chk(err_o == 1'b1 && state_o == ST_SWOUT, "R10 illegal activate", err_o, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule